// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM

This block is a synthesizable cycle model of a synchronous static memory with a separate read data port and a separate write data port. A single address bus is shared in time: rising clock edges alternate between a read slot and a write slot. A pair of consecutive edges forms one window, in which one read and one write can both be accepted. Every access moves four words. Write data arrives on both clock edges. Read data leaves on both clock edges with a one-cycle or a one-and-a-half-cycle latency, chosen by a static mode input.

Each write beat carries a per-lane keep mask, so a single 8-bit lane of a word can be updated alone. A write is committed to the array only after its fourth beat has arrived. A read issued while the previous write is still outstanding is served from a merge of the array and the write's capture registers. Reads therefore always see every write whose address was accepted earlier. The array is a parameterized register file that reset clears.

Top module: `qdr_burst_sram`

## Requirements
- R1: Once reset is released, the first rising edge is a read slot, and rising edges then alternate between read slots and write slots. `rd_sel_n` is sampled only in read slots and `wr_sel_n` only in write slots. In each slot, `addr` is taken as the address of that slot's access.
- R2: A write accepted at a write-slot edge takes four beats from `wdata`/`wkeep`: at that edge, at the following falling edge, at the next rising edge, and at the falling edge after that. Beat k is stored at the word whose two low address bits are (start + k) mod 4, with the upper address bits unchanged.
- R3: A read burst returns four words in the same wrapping order: beat k comes from word (start + k) mod 4 inside the aligned group of four.
- R4: Bit i of `wkeep` at 1 leaves bits [8i+7:8i] of that beat's word unchanged. At 0, the lane is written.
- R5: With `lat_half` = 0, beat k of a read accepted at a rising edge E is driven from the (2 + k)-th clock edge after E, counting both edges. Beat 0 therefore appears one cycle after acceptance.
- R6: With `lat_half` = 1, every read beat appears one clock edge later than in R5, which is 1.5 cycles after acceptance.
- R7: A read returns the effect of every write whose address was accepted before the read slot. This includes the write accepted in the immediately preceding write slot, which has not yet been committed to the array. A write accepted later in the same window is not visible to that read.
- R8: When both selects are held low across a window, the read and the write are both served. Back-to-back windows sustain one read and one write per window.
- R9: `rvalid` is high for exactly the four beats of each read burst. At all other times it is low and `rdata` is all zeros.
- R10: Reset clears the array to zero and drives `rvalid` low and `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled in read slots |
| wr_sel_n | input | 1 | Active-low write request, sampled in write slots |
| lat_half | input | 1 | Static latency mode: 1 selects 1.5 cycles, 0 selects 1 cycle |
| addr | input | AW | Shared word address, read or write depending on slot |
| wdata | input | W | Write data beat |
| wkeep | input | W/LANE | Per-lane keep mask for the current write beat |
| rdata | output | W | Read data beat, zero when idle |
| rvalid | output | 1 | High during the four read beats |

## Verification
Timing is counted in clock edges, rising and falling alike. With `lat_half` low, beat k of a read accepted at edge h is due at edge h+2+k; with `lat_half` high it is due at edge h+3+k. The driver logs the edge index of each accepted read and queues four expected words, each tagged with its due edge. The monitor samples 2 ns after every edge and compares both the word and the edge index. At every other sample it requires `rvalid` low and `rdata` zero. The expected words come from a shadow memory. Each write is applied to that memory after any read issued in the same window, so the forwarding and ordering rules are checked as stated.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int W    = 32,
  parameter int LANE = 8,
  parameter int AW   = 6,
  localparam int NB  = W / LANE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic          lat_half,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [NB-1:0] wkeep,
  output logic [W-1:0]  rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic ph;
  logic racc, rb1, rb2;
  logic wact, wpend;
  logic [AW-1:0] ra, wa;
  logic [W-1:0]  wp0, wp2, wn1, wn3;
  logic [NB-1:0] kp0, kp2, kn1, kn3;
  logic [3:0][W-1:0]  wb, rs, fw;
  logic [3:0][NB-1:0] wm;
  logic [W-1:0] pq, nq;
  logic pv, nv;

  wire rd_go = !ph && !rd_sel_n;
  wire wr_go = ph && !wr_sel_n;

  assign wb = {wn3, wp2, wn1, wp0};
  assign wm = {kn3, kp2, kn1, kp0};
  assign rdata  = clk ? pq : nq;
  assign rvalid = clk ? pv : nv;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [NB-1:0] keep);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < NB; i++)
      if (!keep[i]) r[i*LANE +: LANE] = nw[i*LANE +: LANE];
    return r;
  endfunction

  // read snapshot: array merged with the write still waiting to commit
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [1:0] lo;
      logic [1:0] bi;
      lo = ra[1:0] + 2'(k);
      bi = lo - wa[1:0];
      fw[k] = mem[{ra[AW-1:2], lo}];
      if (wpend && wa[AW-1:2] == ra[AW-1:2]) fw[k] = merge(fw[k], wb[bi], wm[bi]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0;  racc <= 1'b0; rb1 <= 1'b0; rb2 <= 1'b0;
      wact <= 1'b0; wpend <= 1'b0;
      pv <= 1'b0;  pq <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      ph    <= !ph;
      racc  <= rd_go;
      rb1   <= racc;
      rb2   <= rb1;
      wact  <= wr_go;
      wpend <= wact;
      if (rd_go) ra <= addr;
      if (wr_go) begin wa <= addr; wp0 <= wdata; kp0 <= wkeep; end
      if (wact)  begin wp2 <= wdata; kp2 <= wkeep; end
      if (racc) rs <= fw;
      if (wpend)
        for (int k = 0; k < 4; k++)
          mem[{wa[AW-1:2], wa[1:0] + 2'(k)}] <= merge(mem[{wa[AW-1:2], wa[1:0] + 2'(k)}], wb[k], wm[k]);
      pv <= 1'b1;
      if (!lat_half) begin
        if (racc)     pq <= fw[0];
        else if (rb1) pq <= rs[2];
        else begin pv <= 1'b0; pq <= '0; end
      end else begin
        if (rb1)      pq <= rs[1];
        else if (rb2) pq <= rs[3];
        else begin pv <= 1'b0; pq <= '0; end
      end
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      nv <= 1'b0; nq <= '0;
    end else begin
      if (wact)  begin wn1 <= wdata; kn1 <= wkeep; end
      if (wpend) begin wn3 <= wdata; kn3 <= wkeep; end
      nv <= rb1 || rb2;
      if (rb1)      nq <= lat_half ? rs[0] : rs[1];
      else if (rb2) nq <= lat_half ? rs[2] : rs[3];
      else          nq <= '0;
    end
  end

  assert_lat_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (racc && !lat_half) |=> (pv && nv));
  assert_lat_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb1 && lat_half) |=> (pv && nv));
  assert_commit_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wpend |-> ph);
  assert_slot_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(racc && wact));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!racc && !rb1 && !rb2) |=> !pv);
endmodule

// File: tb/qdr_burst_sram_tb.sv
`timescale 1ns/1ps
module qdr_burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32, AW = 6, NB = 4;

  logic clk = 0, rst_n = 0, rd_sel_n = 1, wr_sel_n = 1, lat_half = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [NB-1:0] wkeep = '1;
  logic [W-1:0] rdata;
  logic rvalid;

  qdr_burst_sram #(.W(W), .LANE(8), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .lat_half(lat_half), .addr(addr), .wdata(wdata), .wkeep(wkeep),
    .rdata(rdata), .rvalid(rvalid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, hc = 0;
  bit mon_en = 0, done = 0;
  logic [W-1:0] sh [1 << AW];
  logic [W-1:0] q_data[$];
  int q_hc[$];
  string q_tag[$];
  logic [W-1:0] t2 = '0, t3 = '0;
  logic [NB-1:0] k2 = '1, k3 = '1;

  always @(posedge clk or negedge clk) hc++;

  // monitor: pops the scoreboard when the design emits a beat
  initial forever begin
    @(posedge clk or negedge clk);
    #2;
    if (mon_en) begin
      checks++;
      if (rvalid) begin
        if (q_data.size() == 0) begin
          fails++; $display("FAIL R9 unexpected valid: actual %h expected none", rdata);
        end else begin
          logic [W-1:0] ed; int eh; string et;
          ed = q_data.pop_front(); eh = q_hc.pop_front(); et = q_tag.pop_front();
          if (rdata !== ed) begin
            fails++; $display("FAIL %s data: actual %h expected %h", et, rdata, ed);
          end else if (hc != eh) begin
            fails++; $display("FAIL %s latency: actual edge %0d expected %0d", lat_half ? "R6" : "R5", hc, eh);
          end
        end
      end else begin
        if (rdata !== '0) begin
          fails++; $display("FAIL R9 idle data: actual %h expected 0", rdata);
        end
        if (q_hc.size() != 0 && q_hc[0] < hc) begin
          fails++; $display("FAIL %s missing beat: actual none expected %h at edge %0d",
                            q_tag[0], q_data[0], q_hc[0]);
          void'(q_data.pop_front()); void'(q_hc.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  function automatic logic [3:0][W-1:0] mk(input logic [W-1:0] base);
    for (int k = 0; k < 4; k++) mk[k] = base + W'(k * 32'h0101_0101);
  endfunction

  // one window: read slot edge, then write slot edge; selects held the whole window (R1)
  task automatic window(input bit dr, input int ra, input string tag, input bit dw, input int wa,
                        input logic [3:0][W-1:0] d, input logic [3:0][NB-1:0] m);
    int h;
    rd_sel_n = !dr; wr_sel_n = !dw; addr = AW'(ra); wdata = t2; wkeep = k2;
    @(posedge clk); #1;
    h = hc;
    if (dr)
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] ia;
        ia = {AW'(ra) >> 2, 2'(ra + k)};
        q_data.push_back(sh[ia]); q_hc.push_back(h + 2 + k + (lat_half ? 1 : 0)); q_tag.push_back(tag);
      end
    wdata = t3; wkeep = k3;
    @(negedge clk); #1;
    addr = AW'(wa); wdata = d[0]; wkeep = m[0];
    @(posedge clk); #1;
    wdata = d[1]; wkeep = m[1];
    t2 = d[2]; k2 = m[2]; t3 = d[3]; k3 = m[3];
    @(negedge clk); #1;
    if (dw)
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] ia;
        ia = {AW'(wa) >> 2, 2'(wa + k)};
        for (int i = 0; i < NB; i++) if (!m[k][i]) sh[ia][i*8 +: 8] = d[k][i*8 +: 8];
      end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) window(0, 0, "R9", 0, 0, '0, '1);
  endtask

  task automatic run_set(input logic [W-1:0] s);
    window(1, 5, "R10", 0, 0, '0, '1);                       // unwritten word reads zero (R10)
    window(0, 0, "R2", 1, 8, mk(s ^ 32'hA000_0000), '0);
    idle(1);
    window(1, 8, "R2", 0, 0, '0, '1);                         // plain write then read (R2)
    window(0, 0, "R3", 1, 14, mk(s ^ 32'hB000_0000), '0);     // start at low bits 2: wraps (R2)
    idle(1);
    window(1, 13, "R3", 0, 0, '0, '1);                        // read wraps from low bits 1 (R3)
    window(0, 0, "R4", 1, 20, mk(s ^ 32'hC000_0000), '0);
    window(0, 0, "R4", 1, 20, mk(s ^ 32'h0D0D_0D0D), {4'b1110, 4'b0111, 4'b1010, 4'b0101});
    idle(1);
    window(1, 20, "R4", 0, 0, '0, '1);                        // lane masks (R4)
    window(0, 0, "R7", 1, 32, mk(s ^ 32'h1111_0000), '0);
    idle(1);
    window(0, 0, "R7", 1, 33, mk(s ^ 32'h2222_0000), {4'b0011, 4'b1100, 4'b0000, 4'b1111});
    window(1, 34, "R7", 0, 0, '0, '1);                        // forwarded from uncommitted write (R7)
    window(1, 40, "R7", 1, 40, mk(s ^ 32'h3333_0000), '0);    // same window: read sees old data (R7)
    window(1, 40, "R8", 0, 0, '0, '1);
    for (int i = 0; i < 4; i++)                               // one read and one write per window (R8)
      window(1, 8 + 4 * i, "R8", 1, 48 + 4 * i, mk(s + 32'(i)), '0);
    window(1, 48, "R8", 0, 0, '0, '1);
    window(1, 60, "R8", 0, 0, '0, '1);
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) sh[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;                                                 // reset state (R10)
    if (rvalid !== 1'b0 || rdata !== '0) begin
      fails++; $display("FAIL R10 reset outputs: actual %b/%h expected 0/0", rvalid, rdata);
    end
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk); #1;
    mon_en = 1;
    run_set(32'h0000_1234);                                   // one-cycle latency (R5)
    lat_half = 1;
    idle(2);
    run_set(32'h5A5A_0000);                                   // one-and-a-half-cycle latency (R6)
    checks++;
    if (q_data.size() != 0) begin
      fails++; $display("FAIL R9 beats never seen: actual %0d left expected 0", q_data.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule